// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor request port and a slower memory port. It keeps 16 lines of 32 bytes each, 512 bytes in all, with one valid flag and one stored tag per line. A processor read that finds its line present is answered from the line array. A read that misses first waits until pending writes have reached memory. It then loads the whole line from memory, one 32-bit word per beat, and answers from the refreshed line.

Every processor write updates memory. The write goes into a 4-entry posted write buffer, which empties toward memory independently of the processor. When the write hits, the line data is updated in the same cycle. The compile-time parameter `WRITE_ALLOC` selects what a write miss does. With 0 the cache is left untouched and only the buffered write happens. With 1 the line is filled first and then written. Fill reads and buffer drains share a single request/ready memory interface.

Top module: `dm_wt_cache`

## Requirements
- R1: A 32-bit address is split as byte offset = bits [4:0], line index = bits [8:5], tag = bits [31:9]. The word within a line is bits [4:2]. Two addresses with the same index and different tags evict each other.
- R2: After reset every line is invalid, `cpu_rsp_valid` and `mem_req_valid` are 0, and the first access to any line reports a miss.
- R3: A request is accepted on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both 1. Exactly one cycle later `cpu_rsp_valid` is 1 for one cycle. `cpu_rsp_hit` is 1 only if the indexed line was valid with an equal tag when the request arrived. For a read, `cpu_rsp_rdata` is the current value of the addressed word.
- R4: On a read miss the line is fetched with 8 memory read beats (`mem_req_write`=0), from the line base upward to base+28. The tag and valid flag are then updated and the request is answered with `cpu_rsp_hit`=0.
- R5: A write hit updates the cached word, so a later read hit returns the new value. The write is also queued for memory.
- R6: With `WRITE_ALLOC`=0 a write miss performs no line fetch and does not change the cache. A later read of that line still misses.
- R7: With `WRITE_ALLOC`=1 a write miss fetches the line (8 beats) and then writes it. A later read of that address hits and returns the written value.
- R8: Buffered writes reach memory in the order they were accepted. Each one is a single beat with `mem_req_write`=1, taken on a cycle where `mem_req_valid` and `mem_req_ready` are both 1.
- R9: A write is refused (`cpu_req_ready`=0) only while 4 writes are pending. Ready returns in the cycle after a buffer entry drains.
- R10: A line fetch starts only once the write buffer is empty, so a read that follows a still-buffered write to the same line returns the written value.
- R11: Drains are never issued while a fetch is in progress. A memory request that is not yet taken keeps its address and direction until `mem_req_ready`.
- R12: For the sequence write A, write A, read B, write B, write A (A and B in different lines, both absent), `WRITE_ALLOC`=0 reports four misses and one hit. `WRITE_ALLOC`=1 reports two misses and three hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = word write, 0 = read |
| cpu_req_addr | input | 32 | Byte address (word aligned) |
| cpu_req_wdata | input | 32 | Write data |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_rsp_valid | output | 1 | Response for the request accepted one cycle earlier |
| cpu_rsp_rdata | output | 32 | Read data (0 for writes) |
| cpu_rsp_hit | output | 1 | Request found its line present on arrival |
| mem_req_valid | output | 1 | Memory beat requested |
| mem_req_write | output | 1 | 1 = buffered write drain, 0 = line fetch read |
| mem_req_addr | output | 32 | Memory word address |
| mem_req_wdata | output | 32 | Drain write data |
| mem_req_ready | input | 1 | Memory takes the beat this cycle |
| mem_rsp_rdata | input | 32 | Read data, valid in the cycle a read beat is taken |

## Verification
The checker assumes that the processor keeps address, direction and data steady from raising `cpu_req_valid` until acceptance. It also assumes word-aligned addresses, and that memory presents read data in the same cycle it takes a read beat. The bench drives every request at a falling edge and holds it until it has seen ready, then drops it. Its memory model answers combinationally from its own array with a repeating ready pattern. A hold input can freeze memory to fill the write buffer or to keep a write pending behind a read miss. All addresses stay below 4 KiB so the model covers them. The design's tags still take several values, which gives set conflicts.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag
);

  logic [NUM_LINES-1:0] line_valid;
  logic [TAG_W-1:0]     line_tag [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             sel;

    assign sel = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) t_q <= upd_tag;
    end

    assign line_valid[g] = v_q;
    assign line_tag[g]   = t_q;
  end

  assign lk_hit = line_valid[lk_idx] && (line_tag[lk_idx] == lk_tag);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int WORDS   = 128,
  parameter int WADDR_W = 7,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic [WADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               we,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data
);

  logic [DATA_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) word_q[wr_addr] <= wr_data;
  end

  assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/dmc_post_fifo.sv
module dmc_post_fifo
  import dmc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  wb_entry_t        push_entry,
  input  logic             pop,
  output wb_entry_t        head,
  output logic [CNT_W-1:0] count
);

  wb_entry_t        slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] f_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= f_next(wr_ptr);
      if (pop)  rd_ptr <= f_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = slot[rd_ptr];

endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import dmc_pkg::*;
#(
  parameter int LINE_BYTES  = 32,
  parameter int NUM_LINES   = 16,
  parameter int WB_DEPTH    = 4,
  parameter int WRITE_ALLOC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_hit,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int WPL      = LINE_BYTES / (DATA_W / 8);
  localparam int WSEL_W   = $clog2(WPL);
  localparam int WORDS    = NUM_LINES * WPL;
  localparam int WADDR_W  = IDX_W + WSEL_W;
  localparam int WB_PTR_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
  localparam int WB_CNT_W = WB_PTR_W + 1;
  localparam bit ALLOC    = (WRITE_ALLOC != 0);
  localparam logic [WB_CNT_W-1:0] WB_FULL_CNT = WB_CNT_W'(WB_DEPTH);
  localparam logic [WSEL_W-1:0]   LAST_BEAT   = WSEL_W'(WPL - 1);

  // address arithmetic
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[2 +: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_beat_addr(input logic [TAG_W-1:0]  t,
                                                   input logic [IDX_W-1:0]  i,
                                                   input logic [WSEL_W-1:0] b);
    return {t, i, b, 2'b00};
  endfunction

  // state
  ctl_state_t        state_q;
  logic [TAG_W-1:0]  fill_tag_q;
  logic [IDX_W-1:0]  fill_idx_q;
  logic [WSEL_W-1:0] beat_q;
  logic              miss_seen_q;
  logic              rsp_valid_q;
  logic              rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;

  // request decode
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              lk_hit;
  logic [DATA_W-1:0] line_word;

  assign req_tag  = f_tag(cpu_req_addr);
  assign req_idx  = f_index(cpu_req_addr);
  assign req_word = f_word(cpu_req_addr);

  // write buffer view
  wb_entry_t             wb_head;
  wb_entry_t             wb_in;
  logic [WB_CNT_W-1:0]   wb_count;
  logic                  wb_empty;
  logic                  wb_full;

  assign wb_empty = (wb_count == '0);
  assign wb_full  = (wb_count == WB_FULL_CNT);

  // named events
  logic in_idle;
  logic in_drain;
  logic in_fill;
  logic wr_takes_direct;
  logic need_fill;
  logic ev_accept;
  logic ev_start_miss;
  logic ev_fill_beat;
  logic ev_fill_done;
  logic ev_drain_beat;
  logic ev_wb_push;
  logic ev_hit_write;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_drain = (state_q == ST_DRAIN);
  assign in_fill  = (state_q == ST_FILL);

  assign wr_takes_direct = cpu_req_write && (lk_hit || !ALLOC);
  assign need_fill       = !lk_hit && (!cpu_req_write || ALLOC);

  always_comb begin
    cpu_req_ready = 1'b0;
    if (in_idle) begin
      if (cpu_req_write) cpu_req_ready = wr_takes_direct && !wb_full;
      else               cpu_req_ready = lk_hit;
    end
  end

  assign ev_accept     = cpu_req_valid && cpu_req_ready;
  assign ev_start_miss = in_idle && cpu_req_valid && need_fill;
  assign ev_fill_beat  = in_fill && mem_req_ready;
  assign ev_fill_done  = ev_fill_beat && (beat_q == LAST_BEAT);
  assign ev_drain_beat = !in_fill && !wb_empty && mem_req_ready;
  assign ev_wb_push    = ev_accept && cpu_req_write;
  assign ev_hit_write  = ev_wb_push && lk_hit;

  // controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      fill_tag_q  <= '0;
      fill_idx_q  <= '0;
      beat_q      <= '0;
      miss_seen_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ev_start_miss) begin
            state_q     <= ST_DRAIN;
            fill_tag_q  <= req_tag;
            fill_idx_q  <= req_idx;
            miss_seen_q <= 1'b1;
          end else if (ev_accept) begin
            miss_seen_q <= 1'b0;
          end
        end
        ST_DRAIN: begin
          if (wb_empty) begin
            state_q <= ST_FILL;
            beat_q  <= '0;
          end
        end
        ST_FILL: begin
          if (ev_fill_beat) begin
            beat_q <= beat_q + 1'b1;
            if (ev_fill_done) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= ev_accept;
      if (ev_accept) begin
        rsp_hit_q  <= lk_hit && !miss_seen_q;
        rsp_data_q <= cpu_req_write ? '0 : line_word;
      end
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_hit   = rsp_hit_q;
  assign cpu_rsp_rdata = rsp_data_q;

  // tag and valid storage
  dmc_tag_store #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .TAG_W     (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_idx  (req_idx),
    .lk_tag  (req_tag),
    .lk_hit  (lk_hit),
    .upd_en  (ev_fill_done),
    .upd_idx (fill_idx_q),
    .upd_tag (fill_tag_q)
  );

  // line data storage
  logic               dat_we;
  logic [WADDR_W-1:0] dat_waddr;
  logic [DATA_W-1:0]  dat_wdata;

  always_comb begin
    if (ev_fill_beat) begin
      dat_we    = 1'b1;
      dat_waddr = {fill_idx_q, beat_q};
      dat_wdata = mem_rsp_rdata;
    end else begin
      dat_we    = ev_hit_write;
      dat_waddr = {req_idx, req_word};
      dat_wdata = cpu_req_wdata;
    end
  end

  dmc_data_store #(
    .WORDS   (WORDS),
    .WADDR_W (WADDR_W),
    .DATA_W  (DATA_W)
  ) u_data (
    .clk     (clk),
    .rd_addr ({req_idx, req_word}),
    .rd_data (line_word),
    .we      (dat_we),
    .wr_addr (dat_waddr),
    .wr_data (dat_wdata)
  );

  // posted write buffer
  assign wb_in.addr = cpu_req_addr;
  assign wb_in.data = cpu_req_wdata;

  dmc_post_fifo #(
    .DEPTH (WB_DEPTH),
    .PTR_W (WB_PTR_W),
    .CNT_W (WB_CNT_W)
  ) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ev_wb_push),
    .push_entry (wb_in),
    .pop        (ev_drain_beat),
    .head       (wb_head),
    .count      (wb_count)
  );

  // shared memory port: fetch owns it while filling, drains otherwise
  assign mem_req_valid = in_fill || !wb_empty;
  assign mem_req_write = !in_fill;
  assign mem_req_addr  = in_fill ? f_beat_addr(fill_tag_q, fill_idx_q, beat_q) : wb_head.addr;
  assign mem_req_wdata = wb_head.data;

endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req_valid,
  input logic             cpu_req_write,
  input logic             cpu_req_ready,
  input logic             cpu_rsp_valid,
  input logic             mem_req_valid,
  input logic             mem_req_write,
  input logic [31:0]      mem_req_addr,
  input logic             mem_req_ready,
  input logic [CNT_W-1:0] wb_count,
  input logic             in_fill
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WB_DEPTH);

  // R10: a fetch beat is only requested with the write buffer empty
  a_r10_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (wb_count == '0));

  // R11: no drain beat while a fetch is in progress
  a_r11_no_drain_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> !(mem_req_valid && mem_req_write));

  // R11: a pending memory request is held until taken
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R3: one response per accepted request, one cycle later
  a_r3_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> cpu_rsp_valid);

  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req_valid && cpu_req_ready) |=> !cpu_rsp_valid);

  // R9: buffer never exceeds its depth, no write is taken when full
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= FULL);

  a_r9_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_count == FULL) |-> !(cpu_req_valid && cpu_req_write && cpu_req_ready));

endmodule

bind dm_wt_cache dm_wt_cache_chk #(
  .WB_DEPTH (WB_DEPTH),
  .CNT_W    (WB_CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_write (cpu_req_write),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_ready (mem_req_ready),
  .wb_count      (wb_count),
  .in_fill       (in_fill)
);

// File: tb/dm_wt_cache_bench.sv
module dm_wt_cache_bench_mem #(
  parameter int WORDS = 1024
) (
  input  logic        clk,
  input  logic        hold,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        ready,
  output logic [31:0] rdata,
  output int          rd_beats,
  output logic [31:0] last_rd_addr
);

  logic [31:0] mem [WORDS];
  logic [1:0]  ph;

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 32'hA500_0000 + 32'(i) * 32'd7;
    ph = 2'd0;
    rd_beats = 0;
    last_rd_addr = 32'd0;
  end

  assign ready = !hold && (ph != 2'd3);
  assign rdata = mem[req_addr[11:2]];

  always @(posedge clk) begin
    ph <= ph + 2'd1;
    if (req_valid && ready) begin
      if (req_write) mem[req_addr[11:2]] <= req_wdata;
      else begin
        rd_beats     <= rd_beats + 1;
        last_rd_addr <= req_addr;
      end
    end
  end

endmodule

module dm_wt_cache_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic        cv [2];
  logic        cw [2];
  logic [31:0] ca [2];
  logic [31:0] cd [2];
  logic        crdy [2];
  logic        rv [2];
  logic [31:0] rd [2];
  logic        rh [2];
  logic        mv [2];
  logic        mw [2];
  logic [31:0] ma [2];
  logic [31:0] mwd [2];
  logic        mrdy [2];
  logic [31:0] mrd [2];
  logic        hold [2];
  int          beats [2];
  logic [31:0] lra [2];

  logic [31:0] exp_mem [2][1024];

  dm_wt_cache #(.WRITE_ALLOC(0)) u_dm_wt_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cv[0]), .cpu_req_write(cw[0]), .cpu_req_addr(ca[0]),
    .cpu_req_wdata(cd[0]), .cpu_req_ready(crdy[0]),
    .cpu_rsp_valid(rv[0]), .cpu_rsp_rdata(rd[0]), .cpu_rsp_hit(rh[0]),
    .mem_req_valid(mv[0]), .mem_req_write(mw[0]), .mem_req_addr(ma[0]),
    .mem_req_wdata(mwd[0]), .mem_req_ready(mrdy[0]), .mem_rsp_rdata(mrd[0])
  );

  dm_wt_cache #(.WRITE_ALLOC(1)) u_dm_wt_cache_wa (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cv[1]), .cpu_req_write(cw[1]), .cpu_req_addr(ca[1]),
    .cpu_req_wdata(cd[1]), .cpu_req_ready(crdy[1]),
    .cpu_rsp_valid(rv[1]), .cpu_rsp_rdata(rd[1]), .cpu_rsp_hit(rh[1]),
    .mem_req_valid(mv[1]), .mem_req_write(mw[1]), .mem_req_addr(ma[1]),
    .mem_req_wdata(mwd[1]), .mem_req_ready(mrdy[1]), .mem_rsp_rdata(mrd[1])
  );

  dm_wt_cache_bench_mem u_mem0 (
    .clk(clk), .hold(hold[0]), .req_valid(mv[0]), .req_write(mw[0]),
    .req_addr(ma[0]), .req_wdata(mwd[0]), .ready(mrdy[0]), .rdata(mrd[0]),
    .rd_beats(beats[0]), .last_rd_addr(lra[0])
  );

  dm_wt_cache_bench_mem u_mem1 (
    .clk(clk), .hold(hold[1]), .req_valid(mv[1]), .req_write(mw[1]),
    .req_addr(ma[1]), .req_wdata(mwd[1]), .ready(mrdy[1]), .rdata(mrd[1]),
    .rd_beats(beats[1]), .last_rd_addr(lra[1])
  );

  // vector fields: [65] expected hit, [64] write, [63:32] address, [31:0] data
  localparam int NVEC = 14;
  localparam logic [65:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0000_0044, 32'h0},           // first touch of index 2
    {1'b1, 1'b0, 32'h0000_0048, 32'h0},           // same line
    {1'b1, 1'b1, 32'h0000_004C, 32'h1111_1111},   // write hit
    {1'b1, 1'b0, 32'h0000_004C, 32'h0},           // reads written word
    {1'b0, 1'b0, 32'h0000_0244, 32'h0},           // same index, other tag
    {1'b0, 1'b0, 32'h0000_0048, 32'h0},           // evicted line returns
    {1'b0, 1'b1, 32'h0000_03A0, 32'h2222_2222},   // write miss, no allocate
    {1'b0, 1'b0, 32'h0000_03A0, 32'h0},           // still absent
    {1'b1, 1'b0, 32'h0000_03BC, 32'h0},           // last word of that line
    {1'b0, 1'b1, 32'h0000_0600, 32'h3333_3333},
    {1'b0, 1'b1, 32'h0000_0600, 32'h4444_4444},
    {1'b0, 1'b0, 32'h0000_0600, 32'h0},
    {1'b0, 1'b0, 32'h0000_01FC, 32'h0},           // top index, top word
    {1'b1, 1'b0, 32'h0000_01E0, 32'h0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input int d, input logic wr, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rdat,
                        output logic hit);
    @(negedge clk);
    cv[d] = 1'b1; cw[d] = wr; ca[d] = a; cd[d] = wd;
    forever begin
      #1;
      if (crdy[d]) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R3 response one cycle after accept", 32'(rv[d]), 32'd1);
    rdat = rd[d];
    hit  = rh[d];
    cv[d] = 1'b0;
    if (wr) exp_mem[d][a[11:2]] = wd;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: all requirements actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic        h;
    int          b0;
    int          hits;
    logic [31:0] a_addr;
    logic [31:0] b_addr;

    for (int d = 0; d < 2; d++) begin
      cv[d] = 1'b0; cw[d] = 1'b0; ca[d] = '0; cd[d] = '0; hold[d] = 1'b0;
      for (int i = 0; i < 1024; i++) exp_mem[d][i] = 32'hA500_0000 + 32'(i) * 32'd7;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    for (int d = 0; d < 2; d++) begin
      chk("R2 no response after reset", 32'(rv[d]), 32'd0);
      chk("R2 no memory request after reset", 32'(mv[d]), 32'd0);
    end

    // vector walk on the no-allocate instance: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      logic        xhit;
      logic        xwr;
      logic [31:0] xa;
      xhit = VEC[k][65];
      xwr  = VEC[k][64];
      xa   = VEC[k][63:32];
      b0   = beats[0];
      access(0, xwr, xa, VEC[k][31:0], r, h);
      chk($sformatf("R1/R3 hit flag vector %0d", k), 32'(h), 32'(xhit));
      if (!xwr) chk($sformatf("R3/R5 read data vector %0d", k), r, exp_mem[0][xa[11:2]]);
      if (!xwr && !xhit) begin
        chk($sformatf("R4 fetch beat count vector %0d", k), 32'(beats[0] - b0), 32'd8);
        chk($sformatf("R4 last fetch address vector %0d", k), lra[0], (xa & ~32'h1F) + 32'd28);
      end else begin
        chk($sformatf("R6 no fetch vector %0d", k), 32'(beats[0] - b0), 32'd0);
      end
    end
    idle(30);
    chk("R8 write reached memory", u_mem0.mem[12'h04C >> 2], 32'h1111_1111);
    chk("R8 later write wins", u_mem0.mem[12'h600 >> 2], 32'h4444_4444);

    // R10: read miss behind a still-buffered write to the same line
    hold[0] = 1'b1;
    access(0, 1'b1, 32'h0000_02A0, 32'h5555_5555, r, h);
    fork
      access(0, 1'b0, 32'h0000_02A0, 32'h0, r, h);
      begin idle(6); hold[0] = 1'b0; end
    join
    chk("R10 fetch sees buffered write", r, 32'h5555_5555);
    chk("R10 read reported a miss", 32'(h), 32'd0);
    idle(20);

    // R9 / R8 / R11: fill the buffer with memory frozen
    hold[0] = 1'b1;
    access(0, 1'b1, 32'h0000_0100, 32'hC0DE_0001, r, h);
    access(0, 1'b1, 32'h0000_0104, 32'hC0DE_0002, r, h);
    access(0, 1'b1, 32'h0000_0100, 32'hC0DE_0003, r, h);
    access(0, 1'b1, 32'h0000_0104, 32'hC0DE_0004, r, h);
    @(negedge clk);
    cv[0] = 1'b1; cw[0] = 1'b1; ca[0] = 32'h0000_0108; cd[0] = 32'hC0DE_0005;
    idle(3);
    #1;
    chk("R9 write refused with 4 pending", 32'(crdy[0]), 32'd0);
    @(negedge clk);
    hold[0] = 1'b0;
    for (int t = 0; t < 8; t++) begin
      #1;
      if (mv[0] && mrdy[0]) begin
        chk("R9 still refused in drain cycle", 32'(crdy[0]), 32'd0);
        chk("R8 first drain is oldest address", ma[0], 32'h0000_0100);
        chk("R8 first drain is oldest data", mwd[0], 32'hC0DE_0001);
        chk("R11 drain beat is a write", 32'(mw[0]), 32'd1);
        @(negedge clk);
        #1;
        chk("R9 ready in cycle after drain", 32'(crdy[0]), 32'd1);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cv[0] = 1'b0;
    exp_mem[0][12'h108 >> 2] = 32'hC0DE_0005;
    idle(30);
    chk("R8 ordered drain word 0x100", u_mem0.mem[12'h100 >> 2], 32'hC0DE_0003);
    chk("R8 ordered drain word 0x104", u_mem0.mem[12'h104 >> 2], 32'hC0DE_0004);
    chk("R8 fifth write drained", u_mem0.mem[12'h108 >> 2], 32'hC0DE_0005);

    // R12 sequence on both instances, R7 on the allocating one
    a_addr = 32'h0000_0800;
    b_addr = 32'h0000_0C24;
    for (int d = 0; d < 2; d++) begin
      hits = 0;
      access(d, 1'b1, a_addr, 32'h0A0A_0001, r, h); hits += int'(h);
      access(d, 1'b1, a_addr, 32'h0A0A_0002, r, h); hits += int'(h);
      access(d, 1'b0, b_addr, 32'h0,         r, h); hits += int'(h);
      access(d, 1'b1, b_addr, 32'h0B0B_0003, r, h); hits += int'(h);
      access(d, 1'b1, a_addr, 32'h0A0A_0004, r, h); hits += int'(h);
      chk($sformatf("R12 hit count instance %0d", d), 32'(hits), (d == 0) ? 32'd1 : 32'd3);
    end
    b0 = beats[1];
    access(1, 1'b1, 32'h0000_0E40, 32'h7777_7777, r, h);
    chk("R7 write miss fetches line", 32'(beats[1] - b0), 32'd8);
    chk("R7 write miss reported", 32'(h), 32'd0);
    access(1, 1'b0, 32'h0000_0E40, 32'h0, r, h);
    chk("R7 allocated line hits", 32'(h), 32'd1);
    chk("R7 allocated line holds write", r, 32'h7777_7777);
    access(0, 1'b0, a_addr, 32'h0, r, h);
    chk("R6 no-allocate line still absent", 32'(h), 32'd0);
    chk("R6 read after write miss returns memory value", r, 32'h0A0A_0004);

    idle(5);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule